// File: doc/BRIEF.md
# Receive Frame Classifier Combiner

This block makes the accept decision for a received frame at sixteen independent classifiers. A front end, which is not part of this block, reduces each frame to one 32-bit attribute word. The word carries frame-kind flags, address-hit flags and two filter-bank match vectors. Each classifier compares that word against two enable words it owns:

- The OR enable word asks whether any selected attribute is present.
- The AND enable word asks whether every selected attribute is present.

A two-bit combine mode merges those two answers. A small gate register then either forces the classifier open regardless of the filters, or shuts it.

A register port configures every enable word, the packed combine-mode word and every gate, and returns the stored value of any register for readback. When an attribute word is presented with its valid strobe, the sixteen decisions appear together as an accept vector on the next clock. The vector holds until the next strobe. Firmware typically does two things with it:

- It clears everything to block all receive traffic.
- It opens one classifier for broadcast and own-address frames, and optionally multicast.

Top module: `rx_class_combiner`

## Requirements
- R1: Attribute word bit meaning: bit 31 unicast, bit 30 multicast, bit 29 broadcast, bit 28 forward, bit 27 receive, bit 26 VLAN, bit 25 port-address hit, bit 24 interface-address hit, bits 23:16 first filter bank, bits 15:0 second filter bank. The any-term of classifier n is true when (attr & or_en[n]) is nonzero.
- R2: The all-term of classifier n is true when every bit set in and_en[n] is also set in attr. It is false whenever and_en[n] is zero.
- R3: The combine mode of classifier n sits in bits 2n+1:2n of the mode register. The four codes select these results:
  - 0: the any-term.
  - 1: the all-term.
  - 2: the any-term AND the all-term.
  - 3: the any-term OR the all-term, where the all-term requires and_en nonzero.
- R4: Gate register bit 6 is allow, bit 5 is raw, and bit 4 is phase. Accept for classifier n is allow AND (raw OR mode result). With allow and raw both set, every frame is accepted; with allow clear, nothing is.
- R5: The phase bit is stored and read back but never changes any accept decision.
- R6: A classifier with both enable words zero, mode 0, and raw clear accepts no frame, even an all-ones attribute word.
- R7: accept_valid is high exactly in the cycle after attr_valid is high. accept_vec changes only on an attr_valid cycle and otherwise holds its last value.
- R8: Register map (byte-free word addresses):
  - 0x00+n: AND enable n.
  - 0x10+n: OR enable n.
  - 0x20: mode word.
  - 0x30+n: gate n.

  A read returns the last value written. Gate reads return zero outside bits 6:4. Reads of unmapped addresses return zero, and writes to them change nothing.
- R9: Reset clears every register, accept_valid and accept_vec to zero.
- R10: With OR enable set to broadcast plus port-address hit, mode 3 and allow set, broadcast and own-address frames are accepted. Plain unicast and multicast frames are rejected until the multicast bit is added to the OR enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wen | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (8) | Register word address |
| cfg_wdata | input | ATTR_W (32) | Register write data |
| cfg_rdata | output | ATTR_W (32) | Stored value at cfg_addr (combinational) |
| attr_valid | input | 1 | Attribute word present this cycle |
| attr_word | input | ATTR_W (32) | Per-frame attribute word |
| accept_valid | output | 1 | accept_vec updated this cycle |
| accept_vec | output | NUM_CLS (16) | Per-classifier accept decision |

## Verification
The sweep runs every combine mode against every gate code. The enable words include a zero AND word, so a design that treats an empty AND word as always true (vacuous truth) accepts frames in modes 1 and 3 that it must reject. Walking single bits and pseudo-random attribute words expose any swapped or misaligned mode field, and any classifier that reads another classifier's enables. Gate words differing only in phase must give identical vectors, and a design wrongly gating on phase changes them. Readback of gate and unmapped addresses catches stored junk bits or aliasing writes. Idle cycles with a changing attribute bus catch a vector that updates without the strobe.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

   // attribute word flags (bit positions are decoded by the producer)
   localparam int ATTR_UCAST_BIT  = 31;
   localparam int ATTR_MCAST_BIT  = 30;
   localparam int ATTR_BCAST_BIT  = 29;
   localparam int ATTR_FWD_BIT    = 28;
   localparam int ATTR_RCV_BIT    = 27;
   localparam int ATTR_VLAN_BIT   = 26;
   localparam int ATTR_DA_PORT    = 25;
   localparam int ATTR_DA_IFACE   = 24;

   // gate register fields
   localparam int GATE_ALLOW_BIT  = 6;
   localparam int GATE_RAW_BIT    = 5;
   localparam int GATE_PHASE_BIT  = 4;

   // register map: upper address bits pick a region, low bits a slot
   localparam int SLOT_IDX_W      = 4;
   localparam int RGN_AND         = 0;
   localparam int RGN_OR          = 1;
   localparam int RGN_MODE        = 2;
   localparam int RGN_GATE        = 3;

   typedef enum logic [1:0] {
      CMB_ANY          = 2'd0,
      CMB_ALL          = 2'd1,
      CMB_ANY_AND_ALL  = 2'd2,
      CMB_ANY_OR_ALL   = 2'd3
   } cmb_mode_e;

   typedef struct packed {
      logic allow;
      logic raw;
      logic phase;
   } gate_t;

endpackage

// File: rtl/rfc_regfile.sv
module rfc_regfile
   import rfc_pkg::*;
#(
   parameter int NUM_CLS = 16,
   parameter int ATTR_W  = 32,
   parameter int ADDR_W  = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wen,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [ATTR_W-1:0]             wdata,
   output logic [ATTR_W-1:0]             rdata,
   output logic [NUM_CLS-1:0][ATTR_W-1:0] and_en_o,
   output logic [NUM_CLS-1:0][ATTR_W-1:0] or_en_o,
   output logic [NUM_CLS-1:0][1:0]       mode_o,
   output logic [NUM_CLS-1:0]            allow_o,
   output logic [NUM_CLS-1:0]            raw_o
);

   localparam int RGN_W   = ADDR_W - SLOT_IDX_W;
   localparam int MODE_W  = 2 * NUM_CLS;
   localparam logic [SLOT_IDX_W:0] NUM_CLS_L = (SLOT_IDX_W+1)'(NUM_CLS);

   logic [SLOT_IDX_W-1:0] idx;
   logic [RGN_W-1:0]      rgn;
   logic                  slot_ok;
   logic                  sel_and, sel_or, sel_mode, sel_gate;

   logic [ATTR_W-1:0] and_q  [NUM_CLS];
   logic [ATTR_W-1:0] or_q   [NUM_CLS];
   gate_t             gate_q [NUM_CLS];
   logic [MODE_W-1:0] mode_q;

   assign idx     = addr[SLOT_IDX_W-1:0];
   assign rgn     = addr[ADDR_W-1:SLOT_IDX_W];
   assign slot_ok = ({1'b0, idx} < NUM_CLS_L);

   assign sel_and  = (rgn == RGN_W'(RGN_AND))  && slot_ok;
   assign sel_or   = (rgn == RGN_W'(RGN_OR))   && slot_ok;
   assign sel_gate = (rgn == RGN_W'(RGN_GATE)) && slot_ok;
   assign sel_mode = (rgn == RGN_W'(RGN_MODE)) && (idx == '0);

   generate
      for (genvar n = 0; n < NUM_CLS; n++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               and_q[n]  <= '0;
               or_q[n]   <= '0;
               gate_q[n] <= '0;
            end else if (wen && (idx == SLOT_IDX_W'(n))) begin
               if (sel_and)  and_q[n] <= wdata;
               if (sel_or)   or_q[n]  <= wdata;
               if (sel_gate) begin
                  gate_q[n].allow <= wdata[GATE_ALLOW_BIT];
                  gate_q[n].raw   <= wdata[GATE_RAW_BIT];
                  gate_q[n].phase <= wdata[GATE_PHASE_BIT];
               end
            end
         end

         assign and_en_o[n] = and_q[n];
         assign or_en_o[n]  = or_q[n];
         assign mode_o[n]   = mode_q[2*n +: 2];
         assign allow_o[n]  = gate_q[n].allow;
         assign raw_o[n]    = gate_q[n].raw;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                mode_q <= '0;
      else if (wen && sel_mode)  mode_q <= wdata[MODE_W-1:0];
   end

   always_comb begin
      rdata = '0;
      if (sel_and)       rdata = and_q[idx];
      else if (sel_or)   rdata = or_q[idx];
      else if (sel_mode) rdata = ATTR_W'(mode_q);
      else if (sel_gate) begin
         rdata[GATE_ALLOW_BIT] = gate_q[idx].allow;
         rdata[GATE_RAW_BIT]   = gate_q[idx].raw;
         rdata[GATE_PHASE_BIT] = gate_q[idx].phase;
      end
   end

   // R8
   mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wen && sel_mode) |=> (mode_q == $past(wdata[MODE_W-1:0])));

endmodule

// File: rtl/rfc_cls_eval.sv
module rfc_cls_eval
   import rfc_pkg::*;
#(
   parameter int ATTR_W = 32
) (
   input  logic [ATTR_W-1:0] attr,
   input  logic [ATTR_W-1:0] and_en,
   input  logic [ATTR_W-1:0] or_en,
   input  logic [1:0]        mode,
   input  logic              allow,
   input  logic              raw,
   output logic              hit
);

   logic any_t, all_armed, all_t, comb_t;

   assign any_t     = |(attr & or_en);
   assign all_armed = |and_en;
   assign all_t     = all_armed && ((attr & and_en) == and_en);

   always_comb begin
      unique case (cmb_mode_e'(mode))
         CMB_ANY:          comb_t = any_t;
         CMB_ALL:          comb_t = all_t;
         CMB_ANY_AND_ALL:  comb_t = any_t && all_t;
         CMB_ANY_OR_ALL:   comb_t = any_t || all_t;
         default:          comb_t = 1'b0;
      endcase
   end

   assign hit = allow && (raw || comb_t);

endmodule

// File: rtl/rfc_out_stage.sv
module rfc_out_stage #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic         vld_o,
   output logic [W-1:0] dout
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         dout  <= '0;
      end else begin
         vld_o <= load;
         if (load) dout <= din;
      end
   end

endmodule

// File: rtl/rx_class_combiner.sv
module rx_class_combiner
   import rfc_pkg::*;
#(
   parameter int NUM_CLS = 16,
   parameter int ATTR_W  = 32,
   parameter int ADDR_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wen,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [ATTR_W-1:0]  cfg_wdata,
   output logic [ATTR_W-1:0]  cfg_rdata,
   input  logic               attr_valid,
   input  logic [ATTR_W-1:0]  attr_word,
   output logic               accept_valid,
   output logic [NUM_CLS-1:0] accept_vec
);

   generate
      if (NUM_CLS < 1 || NUM_CLS > (1 << SLOT_IDX_W)) begin : g_bad_cls
         $error("NUM_CLS must lie in 1..16");
      end
      if (2 * NUM_CLS > ATTR_W) begin : g_bad_mode
         $error("mode word does not fit ATTR_W");
      end
      if (ATTR_W <= ATTR_UCAST_BIT) begin : g_bad_attr
         $error("ATTR_W too narrow for the attribute flags");
      end
      if (ADDR_W < SLOT_IDX_W + 2) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [NUM_CLS-1:0][ATTR_W-1:0] and_en, or_en;
   logic [NUM_CLS-1:0][1:0]        mode;
   logic [NUM_CLS-1:0]             allow, raw;
   logic [NUM_CLS-1:0]             hit;

   rfc_regfile #(.NUM_CLS(NUM_CLS), .ATTR_W(ATTR_W), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wen      (cfg_wen),
      .addr     (cfg_addr),
      .wdata    (cfg_wdata),
      .rdata    (cfg_rdata),
      .and_en_o (and_en),
      .or_en_o  (or_en),
      .mode_o   (mode),
      .allow_o  (allow),
      .raw_o    (raw)
   );

   generate
      for (genvar n = 0; n < NUM_CLS; n++) begin : g_cls
         rfc_cls_eval #(.ATTR_W(ATTR_W)) u_eval (
            .attr   (attr_word),
            .and_en (and_en[n]),
            .or_en  (or_en[n]),
            .mode   (mode[n]),
            .allow  (allow[n]),
            .raw    (raw[n]),
            .hit    (hit[n])
         );

         // R4
         gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (attr_valid && !allow[n]) |=> !accept_vec[n]);

         // R4
         raw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (attr_valid && allow[n] && raw[n]) |=> accept_vec[n]);

         // R6
         empty_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (attr_valid && !raw[n] && (mode[n] == 2'd0) && (or_en[n] == '0))
            |=> !accept_vec[n]);
      end
   endgenerate

   rfc_out_stage #(.W(NUM_CLS)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (attr_valid),
      .din   (hit),
      .vld_o (accept_valid),
      .dout  (accept_vec)
   );

   // R7
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      attr_valid |=> accept_valid);

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !attr_valid |=> ($stable(accept_vec) && !accept_valid));

endmodule

// File: tb/sim_rx_class_combiner.sv
`timescale 1ns/100ps
module sim_rx_class_combiner;

   localparam int NC = 16;
   localparam int AW = 32;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wen = 1'b0;
   logic [DW-1:0] cfg_addr = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic [AW-1:0] cfg_rdata;
   logic          attr_valid = 1'b0;
   logic [AW-1:0] attr_word = '0;
   logic          accept_valid;
   logic [NC-1:0] accept_vec;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   logic [AW-1:0] m_and [NC];
   logic [AW-1:0] m_or  [NC];
   logic [1:0]    m_mode[NC];
   logic [2:0]    m_gate[NC];   // {allow, raw, phase}

   always #2.5 clk = ~clk;

   rx_class_combiner #(.NUM_CLS(NC), .ATTR_W(AW), .ADDR_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wen(cfg_wen), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .attr_valid(attr_valid),
      .attr_word(attr_word), .accept_valid(accept_valid), .accept_vec(accept_vec)
   );

   function automatic logic model_hit(int n, logic [AW-1:0] a);
      logic any_t, all_t, r;
      any_t = (a & m_or[n]) != 0;
      all_t = (m_and[n] != 0) && ((a & m_and[n]) == m_and[n]);
      case (m_mode[n])
         2'd0: r = any_t;
         2'd1: r = all_t;
         2'd2: r = any_t & all_t;
         default: r = any_t | all_t;
      endcase
      return m_gate[n][2] & (m_gate[n][1] | r);
   endfunction

   function automatic logic [NC-1:0] model_vec(logic [AW-1:0] a);
      logic [NC-1:0] v;
      for (int n = 0; n < NC; n++) v[n] = model_hit(n, a);
      return v;
   endfunction

   task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [DW-1:0] a, logic [AW-1:0] d);
      @(negedge clk);
      cfg_wen = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wen = 1'b0;
   endtask

   task automatic rd_check(string req, logic [DW-1:0] a, logic [AW-1:0] exp);
      @(negedge clk);
      cfg_addr = a;
      #1;
      check(req, cfg_rdata, exp);
   endtask

   task automatic load_all();
      logic [AW-1:0] mw;
      mw = '0;
      for (int n = 0; n < NC; n++) begin
         wr(DW'(8'h00 + n), m_and[n]);
         wr(DW'(8'h10 + n), m_or[n]);
         wr(DW'(8'h30 + n), AW'({m_gate[n], 4'b0}));
         mw[2*n +: 2] = m_mode[n];
      end
      wr(8'h20, mw);
   endtask

   task automatic apply(string req, logic [AW-1:0] a);
      @(negedge clk);
      attr_valid = 1'b1; attr_word = a;
      @(negedge clk);
      attr_valid = 1'b0;
      #1;
      check({req, " valid"}, AW'(accept_valid), AW'(1));
      check(req, AW'(accept_vec), AW'(model_vec(a)));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] s, a, held;
      for (int n = 0; n < NC; n++) begin
         m_and[n] = '0; m_or[n] = '0; m_mode[n] = '0; m_gate[n] = '0;
      end
      repeat (3) @(negedge clk);
      // R9 reset state
      #1;
      check("R9 accept_valid", AW'(accept_valid), '0);
      check("R9 accept_vec", AW'(accept_vec), '0);
      rst_n = 1'b1;
      rd_check("R9 and0", 8'h00, '0);
      rd_check("R9 or15", 8'h1F, '0);
      rd_check("R9 mode", 8'h20, '0);
      rd_check("R9 gate7", 8'h37, '0);

      // R8 readback, gate field masking, unmapped addresses
      wr(8'h05, 32'hA5A5_0F0F);
      rd_check("R8 and5", 8'h05, 32'hA5A5_0F0F);
      wr(8'h1C, 32'h1234_5678);
      rd_check("R8 or12", 8'h1C, 32'h1234_5678);
      wr(8'h37, 32'hFFFF_FFFF);
      rd_check("R8 gate7 mask", 8'h37, 32'h0000_0070);
      wr(8'h20, 32'hC3C3_1E1E);
      rd_check("R8 mode", 8'h20, 32'hC3C3_1E1E);
      wr(8'h24, 32'hDEAD_BEEF);
      rd_check("R8 unmapped 0x24", 8'h24, '0);
      wr(8'h85, 32'hDEAD_BEEF);
      rd_check("R8 unmapped 0x85", 8'h85, '0);
      rd_check("R8 and5 untouched", 8'h05, 32'hA5A5_0F0F);

      // R1 R2 R3 R4 sweep over modes, gates and enable patterns
      for (int p = 0; p < 8; p++) begin
         for (int n = 0; n < NC; n++) begin
            m_mode[n] = 2'(n % 4);
            case (n / 4)
               0: m_and[n] = 32'h0;
               1: m_and[n] = 32'h2000_0000;
               2: m_and[n] = 32'h0300_0001;
               default: m_and[n] = 32'h8000_8000;
            endcase
            m_or[n] = ((n % 3 == 2) && (n < 8)) ? 32'h0 : (32'h2200_0030 << (n % 3));
            m_gate[n] = 3'(p + n);
         end
         load_all();
         s = 32'h1234_5678 ^ AW'(p);
         for (int k = 0; k < 74; k++) begin
            if (k == 0) a = '0;
            else if (k == 1) a = '1;
            else if (k < 34) a = AW'(1) << (k - 2);
            else begin
               s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
               a = s;
            end
            apply("R1 R2 R3 R4 sweep", a);
         end
      end

      // R7 hold with bus activity but no strobe
      held = AW'(accept_vec);
      @(negedge clk); attr_word = 32'hFFFF_FFFF;
      @(negedge clk); attr_word = 32'h0;
      #1;
      check("R7 no valid", AW'(accept_valid), '0);
      check("R7 hold", AW'(accept_vec), held);

      // R5 phase has no effect
      for (int n = 0; n < NC; n++) begin
         m_mode[n] = 2'd3; m_and[n] = 32'h0C00_0000; m_or[n] = 32'h0001_0000 << n;
         m_gate[n] = 3'b100;
      end
      load_all();
      apply("R5 phase clear", 32'h0C00_0000);
      held = AW'(accept_vec);
      for (int n = 0; n < NC; n++) begin
         m_gate[n] = 3'b101;
         wr(DW'(8'h30 + n), 32'h50);
      end
      apply("R5 phase set", 32'h0C00_0000);
      check("R5 phase same vector", AW'(accept_vec), held);

      // R6 everything disabled
      for (int n = 0; n < NC; n++) begin
         m_mode[n] = 2'd0; m_and[n] = '0; m_or[n] = '0; m_gate[n] = 3'b100;
      end
      load_all();
      apply("R6 disabled ones", 32'hFFFF_FFFF);
      check("R6 no accept", AW'(accept_vec), '0);

      // R10 broadcast / own-address profile on classifier 0
      m_or[0] = 32'h2200_0000; m_mode[0] = 2'd3; m_gate[0] = 3'b100;
      load_all();
      apply("R10 broadcast", 32'h2000_0000);
      check("R10 broadcast accepted", AW'(accept_vec[0]), AW'(1));
      apply("R10 own address", 32'h8200_0000);
      check("R10 own accepted", AW'(accept_vec[0]), AW'(1));
      apply("R10 unicast", 32'h8000_0000);
      check("R10 unicast rejected", AW'(accept_vec[0]), AW'(0));
      apply("R10 multicast off", 32'h4000_0000);
      check("R10 multicast rejected", AW'(accept_vec[0]), AW'(0));
      m_or[0] = 32'h6200_0000;
      wr(8'h10, m_or[0]);
      apply("R10 multicast on", 32'h4000_0000);
      check("R10 multicast accepted", AW'(accept_vec[0]), AW'(1));

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule